// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits beside the load path of a load/store unit. On each cycle it takes one load (byte address and size) and looks at every entry of the completed-store queue. From that it decides one of three outcomes: the load takes its data from a queued store, the load goes to the cache, or the load must stall. The block drives the forwarded data and a stall reason that the cache-port arbiter can use. For example, a partial-overlap stall tells the arbiter to favour draining the store.

Only the youngest store whose byte range overlaps the load's byte range is considered. That store can supply data only under two conditions: its data has already arrived, and the load's bytes lie entirely inside the store's bytes. If the load fits inside the store but the store's data is still missing, the load waits. Any overlap that is not full containment also makes the load wait. Bytes are never merged from several sources.

Top module: `ldst_fwd_check`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs `fwd_hit`, `ld_stall`, `stall_cause` and `fwd_data` are all cleared to zero.
- R2: A valid load that overlaps no valid queue entry produces `fwd_hit`=0, `ld_stall`=0, `stall_cause`=0 and `fwd_data`=0. While `fwd_hit` is low, `fwd_data` is always zero.
- R3: A load that lies entirely inside the selected store, whose data flag is set, produces `fwd_hit`=1. `fwd_data` then holds the store's bytes starting at byte offset (load address − store address), with the bytes above the load size zero-filled.
- R4: A load that lies entirely inside the selected store, whose data flag is clear, produces `ld_stall`=1, `fwd_hit`=0 and `stall_cause`=2 (data pending).
- R5: A load that overlaps the selected store only in part produces `ld_stall`=1, `fwd_hit`=0 and `stall_cause`=1 (partial overlap). This holds whatever the store's data flag is.
- R6: When several valid entries overlap the load, the one with the highest index (the youngest in program order) alone decides the result. Older entries have no effect.
- R7: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Data is little-endian: data bits [7:0] hold the byte at the entry's or load's own address. Byte ranges are [addr, addr+size) and are computed without address wrap-around.
- R8: An entry with its valid bit clear is ignored, even if its range overlaps the load.
- R9: When `ld_valid` is low, the next outputs are `fwd_hit`=0, `ld_stall`=0, `stall_cause`=0 and `fwd_data`=0.
- R10: Each result is registered. It appears at the first rising edge after its inputs are applied and does not change before that edge.
- R11: `fwd_hit` and `ld_stall` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code (0:1B, 1:2B, 2:4B, 3:8B) |
| q_valid | input | DEPTH | Queue entry holds a store; bit i is entry i, a higher index is younger |
| q_data_ok | input | DEPTH | Store data for the entry has arrived |
| q_addr | input | DEPTH*ADDR_W | Entry byte addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| q_size | input | DEPTH*2 | Entry size codes, entry i at bits [i*2 +: 2] |
| q_data | input | DEPTH*64 | Entry store data, entry i at bits [i*64 +: 64], little-endian |
| fwd_hit | output | 1 | Load takes its data from a queued store |
| fwd_data | output | 64 | Forwarded bytes, zero-filled above the load size |
| ld_stall | output | 1 | Load must wait |
| stall_cause | output | 2 | 0: none, 1: partial overlap, 2: data pending |

## Verification
Every result is due exactly one rising edge after its load and queue inputs are applied. The bench drives each vector on a falling edge and compares all four outputs on the next falling edge, once the single register stage has captured the result. One vector is also sampled shortly after it is applied and before that edge, to show that the output still holds the previous result. Because inputs are only ever changed on falling edges, each comparison sees the one result that belongs to its vector.

// File: rtl/ldst_fwd_pkg.sv
package ldst_fwd_pkg;

  localparam int unsigned LANE_BYTES = 8;
  localparam int unsigned LANE_W     = LANE_BYTES * 8;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_PARTIAL = 2'd1,
    CAUSE_PENDING = 2'd2
  } stall_cause_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/ldst_fwd_range.sv
module ldst_fwd_range
  import ldst_fwd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              st_live,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_code,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_code,
  output logic              overlap,
  output logic              contain,
  output logic [2:0]        offset
);

  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi, diff;

  // Ranges are [lo, hi); the extra bit keeps hi from wrapping.
  always_comb begin
    ld_lo   = {1'b0, ld_addr};
    st_lo   = {1'b0, st_addr};
    ld_hi   = ld_lo + EW'(size_bytes(ld_code));
    st_hi   = st_lo + EW'(size_bytes(st_code));
    overlap = st_live && (ld_lo < st_hi) && (st_lo < ld_hi);
    contain = overlap && (ld_lo >= st_lo) && (ld_hi <= st_hi);
    diff    = ld_lo - st_lo;
    offset  = diff[2:0];
  end

endmodule

// File: rtl/ldst_fwd_pick.sv
module ldst_fwd_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // The highest index is the youngest store, so later iterations win.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ldst_fwd_extract.sv
module ldst_fwd_extract
  import ldst_fwd_pkg::*;
(
  input  logic [LANE_W-1:0] st_data,
  input  logic [2:0]        offset,
  input  logic [1:0]        ld_code,
  output logic [LANE_W-1:0] ld_data
);

  logic [LANE_W-1:0] shifted;

  always_comb begin
    shifted = st_data >> {offset, 3'b000};
    unique case (ld_code)
      2'd0:    ld_data = {56'd0, shifted[7:0]};
      2'd1:    ld_data = {48'd0, shifted[15:0]};
      2'd2:    ld_data = {32'd0, shifted[31:0]};
      default: ld_data = shifted;
    endcase
  end

endmodule

// File: rtl/ldst_fwd_check.sv
module ldst_fwd_check
  import ldst_fwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_valid,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [1:0]               ld_size,
  input  logic [DEPTH-1:0]         q_valid,
  input  logic [DEPTH-1:0]         q_data_ok,
  input  logic [DEPTH*ADDR_W-1:0]  q_addr,
  input  logic [DEPTH*2-1:0]       q_size,
  input  logic [DEPTH*64-1:0]      q_data,
  output logic                     fwd_hit,
  output logic [63:0]              fwd_data,
  output logic                     ld_stall,
  output logic [1:0]               stall_cause
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [1:0]        e_size [DEPTH];
  logic [LANE_W-1:0] e_data [DEPTH];
  logic [2:0]        e_off  [DEPTH];
  logic [DEPTH-1:0]  e_overlap, e_contain;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign e_addr[g] = q_addr[g*ADDR_W +: ADDR_W];
    assign e_size[g] = q_size[g*2 +: 2];
    assign e_data[g] = q_data[g*LANE_W +: LANE_W];

    ldst_fwd_range #(.ADDR_W(ADDR_W)) range_i (
      .st_live (q_valid[g]),
      .ld_addr (ld_addr),
      .ld_code (ld_size),
      .st_addr (e_addr[g]),
      .st_code (e_size[g]),
      .overlap (e_overlap[g]),
      .contain (e_contain[g]),
      .offset  (e_off[g])
    );
  end

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;

  ldst_fwd_pick #(.DEPTH(DEPTH)) pick_i (
    .cand  (e_overlap),
    .found (sel_found),
    .idx   (sel_idx)
  );

  logic [LANE_W-1:0] sel_bytes;

  ldst_fwd_extract extract_i (
    .st_data (e_data[sel_idx]),
    .offset  (e_off[sel_idx]),
    .ld_code (ld_size),
    .ld_data (sel_bytes)
  );

  logic              nxt_hit, nxt_stall;
  stall_cause_e      nxt_cause;
  logic [LANE_W-1:0] nxt_data;

  always_comb begin
    nxt_hit   = 1'b0;
    nxt_stall = 1'b0;
    nxt_cause = CAUSE_NONE;
    nxt_data  = '0;
    if (ld_valid && sel_found) begin
      if (!e_contain[sel_idx]) begin
        nxt_stall = 1'b1;
        nxt_cause = CAUSE_PARTIAL;
      end else if (!q_data_ok[sel_idx]) begin
        nxt_stall = 1'b1;
        nxt_cause = CAUSE_PENDING;
      end else begin
        nxt_hit  = 1'b1;
        nxt_data = sel_bytes;
      end
    end
  end

  stall_cause_e cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      ld_stall <= 1'b0;
      cause_q  <= CAUSE_NONE;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= nxt_hit;
      ld_stall <= nxt_stall;
      cause_q  <= nxt_cause;
      fwd_data <= nxt_data;
    end
  end

  assign stall_cause = cause_q;

  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fwd_hit && ld_stall)); // R11
  AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
    ld_stall == (stall_cause != 2'd0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!fwd_hit && !ld_stall && fwd_data == 64'd0)); // R9
  AST_NO_DATA_WITHOUT_HIT: assert property (@(posedge clk) disable iff (rst)
    !fwd_hit |-> fwd_data == 64'd0); // R2
  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_size == 2'd0) |=> fwd_data[63:8] == 56'd0); // R7
  AST_EMPTY_QUEUE_PASS: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && q_valid == '0) |=> (!fwd_hit && !ld_stall)); // R8

endmodule

// File: tb/ldst_fwd_check_tb.sv
module ldst_fwd_check_tb_top;

  localparam int AW = 5;
  localparam int DP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr  = '0;
  logic [1:0]    ld_size  = '0;
  logic          b_v  [DP];
  logic          b_ok [DP];
  logic [AW-1:0] b_a  [DP];
  logic [1:0]    b_s  [DP];
  logic [63:0]   b_d  [DP];

  logic [DP-1:0]    q_valid, q_data_ok;
  logic [DP*AW-1:0] q_addr;
  logic [DP*2-1:0]  q_size;
  logic [DP*64-1:0] q_data;

  always_comb begin
    for (int i = 0; i < DP; i++) begin
      q_valid[i]            = b_v[i];
      q_data_ok[i]          = b_ok[i];
      q_addr[i*AW +: AW]    = b_a[i];
      q_size[i*2 +: 2]      = b_s[i];
      q_data[i*64 +: 64]    = b_d[i];
    end
  end

  logic        fwd_hit, ld_stall;
  logic [63:0] fwd_data;
  logic [1:0]  stall_cause;

  ldst_fwd_check #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .q_valid(q_valid), .q_data_ok(q_data_ok), .q_addr(q_addr), .q_size(q_size),
    .q_data(q_data), .fwd_hit(fwd_hit), .fwd_data(fwd_data), .ld_stall(ld_stall),
    .stall_cause(stall_cause)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic        x_hit, x_stall;
  logic [1:0]  x_cause;
  logic [63:0] x_data;

  // Expected result from the requirements: youngest overlapping valid entry decides.
  task automatic model();
    bit found = 0;
    x_hit = 0; x_stall = 0; x_cause = 0; x_data = 0;
    if (ld_valid) begin
      for (int i = DP - 1; i >= 0; i--) begin
        int ls, le, ss, se;
        ls = int'(ld_addr); le = ls + (1 << ld_size);
        ss = int'(b_a[i]);  se = ss + (1 << b_s[i]);
        if (!found && b_v[i] && ls < se && ss < le) begin
          found = 1;
          if (ls >= ss && le <= se) begin
            if (b_ok[i]) begin
              x_hit  = 1;
              x_data = b_d[i] >> (8 * (ls - ss));
              if (ld_size != 2'd3) x_data = x_data & ((64'd1 << (8 * (1 << ld_size))) - 64'd1);
            end else begin
              x_stall = 1; x_cause = 2;
            end
          end else begin
            x_stall = 1; x_cause = 1;
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    n_checks++;
    if (fwd_hit !== x_hit || ld_stall !== x_stall || stall_cause !== x_cause ||
        fwd_data !== x_data || (fwd_hit && ld_stall)) begin
      n_fail++;
      $display("FAIL %s ld=%0d/%0d hit=%0d exp %0d stall=%0d exp %0d cause=%0d exp %0d data=%h exp %h",
               tag, ld_addr, ld_size, fwd_hit, x_hit, ld_stall, x_stall, stall_cause, x_cause,
               fwd_data, x_data);
    end
  endtask

  function automatic string auto_tag();
    if (!ld_valid) return "R9";
    if (x_hit) return "R3";
    if (x_cause == 2'd2) return "R4";
    if (x_cause == 2'd1) return "R5";
    return "R2";
  endfunction

  // Drive at a falling edge, then check at the next falling edge (one register stage).
  task automatic run_vec(input string tag);
    model();
    @(negedge clk);
    compare(tag == "" ? auto_tag() : tag);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    for (int i = 0; i < DP; i++) begin
      b_v[i] = 0; b_ok[i] = 0; b_a[i] = 0; b_s[i] = 0; b_d[i] = 64'h0;
    end
    // R1: reset with a forwarding vector applied
    b_v[0] = 1; b_ok[0] = 1; b_a[0] = 5'd8; b_s[0] = 2'd3; b_d[0] = 64'h8877_6655_4433_2211;
    ld_valid = 1; ld_addr = 5'd8; ld_size = 2'd3;
    repeat (3) @(negedge clk);
    x_hit = 0; x_stall = 0; x_cause = 0; x_data = 0;
    compare("R1");
    rst = 0;
    ld_valid = 0;
    @(negedge clk);
    run_vec("R9");

    // R10: result not visible before the edge, visible after it
    ld_valid = 1; ld_addr = 5'd10; ld_size = 2'd1;
    #1;
    x_hit = 0; x_stall = 0; x_cause = 0; x_data = 0;
    compare("R10");
    run_vec("R10");

    // R7 / R3 / R4 / R5 / R2: exhaustive single-entry sweep
    b_v[1] = 0;
    for (int sa = 0; sa < 32; sa++)
      for (int sc = 0; sc < 4; sc++)
        for (int la = 0; la < 32; la++)
          for (int lc = 0; lc < 4; lc++)
            for (int ok = 0; ok < 2; ok++) begin
              seed = nxt(seed);
              b_v[0] = 1; b_ok[0] = ok[0]; b_a[0] = AW'(sa); b_s[0] = 2'(sc);
              b_d[0] = {seed, ~seed ^ 32'(sa * 977 + la)};
              ld_valid = 1; ld_addr = AW'(la); ld_size = 2'(lc);
              run_vec("");
            end

    // R8: invalid entry overlapping the load is ignored
    for (int la = 0; la < 8; la++) begin
      b_v[0] = 0; b_ok[0] = 1; b_a[0] = 5'd0; b_s[0] = 2'd3;
      b_v[1] = 0; b_ok[1] = 0; b_a[1] = 5'd0; b_s[1] = 2'd3;
      ld_valid = 1; ld_addr = AW'(la); ld_size = 2'd0;
      run_vec("R8");
    end

    // R6: two entries, youngest overlapping one decides
    b_v[0] = 1; b_ok[0] = 1; b_a[0] = 5'd0; b_s[0] = 2'd3; b_d[0] = 64'h0706_0504_0302_0100;
    b_v[1] = 1; b_ok[1] = 1; b_a[1] = 5'd2; b_s[1] = 2'd0; b_d[1] = 64'h0000_0000_0000_00AA;
    ld_valid = 1; ld_addr = 5'd0; ld_size = 2'd2;
    run_vec("R6");
    if (!(x_stall && x_cause == 2'd1)) begin n_checks++; n_fail++; $display("FAIL R6 model"); end
    ld_addr = 5'd2; ld_size = 2'd0;
    run_vec("R6");
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < DP; i++) begin
        seed = nxt(seed);
        b_v[i] = seed[31] | seed[30]; b_ok[i] = seed[29] | seed[28];
        b_a[i] = AW'(seed[20:16] & 5'h0F); b_s[i] = seed[25:24];
        b_d[i] = {seed, nxt(seed)};
      end
      seed = nxt(seed);
      ld_valid = seed[27] | seed[26] | seed[25];
      ld_addr = AW'(seed[20:16] & 5'h0F); ld_size = seed[23:22];
      run_vec("R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule